// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the two-wire serial-bus slave that sits in front of a byte-addressed nonvolatile memory of 64 Ki locations. It samples SCL and SDA on the system clock, recognises Start and Stop conditions, decodes the device select byte against three strap inputs, gathers a 16-bit address and acknowledges every byte it accepts. Accepted write data bytes leave the block as single-cycle write strobes towards a separate write controller. Read bytes are fetched from a synchronous RAM port with one cycle of latency and shifted out most significant bit first.

One address counter serves both directions. A write command that stops after its two address bytes and is followed by a repeated Start leaves the counter pointing at the new address, so the next read-mode select returns that location. Reads continue through consecutive addresses for as long as the master acknowledges, and the counter wraps from FFFFh to 0000h. While the write controller reports busy, the block declines every select byte.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the slave does not drive SDA and issues no write strobe; a Start (SDA falling while SCL is high) begins select decoding and a Stop (SDA rising while SCL is high) returns the slave to standby.
- R2: The select byte arrives MSB first as {1010, three chip-enable bits, RW}; the slave pulls SDA low in the ninth slot only when the identifier is 1010 and the three chip-enable bits equal `chip_sel_i` (bit 3 of the byte against `chip_sel_i[2]`); otherwise it stays silent, ignoring all further bytes, until the next Start.
- R3: While `wr_busy_i` is high, a select byte is never acknowledged, whatever its content.
- R4: After a write-mode select (RW = 0) the slave acknowledges the high address byte then the low address byte; each following data byte is acknowledged and produces one single-cycle `mem_wr_en_o` strobe carrying the counter address and the byte, after which the counter advances by one.
- R5: A read-mode select (RW = 1) issued without a preceding address returns the byte at the current counter value, MSB first, and then advances the counter.
- R6: A write-mode select with two address bytes followed by a repeated Start and a read-mode select returns the byte at the address just sent.
- R7: Every byte transferred (read or written) advances the shared counter by one, wrapping from FFFFh to 0000h.
- R8: When the master leaves SDA high in the ninth slot of a read byte, the slave stops driving and stays silent until the next Start.
- R9: The slave only changes its SDA drive while SCL is low; during an SCL high phase its drive is stable.
- R10: A Start received in the middle of a command (inside a byte or after a partial address) restarts select decoding without loading the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired-AND result) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| chip_sel_i | input | 3 | Strap value the chip-enable bits must match |
| wr_busy_i | input | 1 | Write controller busy; blocks select acknowledge |
| mem_rd_addr_o | output | 16 | Read address to the RAM port (the counter) |
| mem_rd_data_i | input | 8 | RAM read data, one cycle after the address |
| mem_wr_en_o | output | 1 | Single-cycle write strobe |
| mem_wr_addr_o | output | 16 | Address of the strobed byte |
| mem_wr_data_o | output | 8 | Data of the strobed byte |

## Verification
The two functions that can meet in one cycle are Start detection and the byte decoder advancing through its bit and acknowledge slots: a repeated Start can land when a partial select byte has been shifted or when only the high address byte has been taken. The bench provokes both, once after four select bits and once after the high address byte, then judges that the following read-mode select is acknowledged and returns the byte at the counter left by earlier traffic, proving the counter was not loaded. A second meeting point, the counter increment on the last byte at FFFFh, is driven by a write and then a read across the wrap.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_bus_sampler.sv
module i2cs_bus_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi_o,
  output logic sda_hi_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_ff, sda_ff;
  logic          scl_d, sda_d;

  // synchronizer chains plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[LAST-1:0], scl_i};
      sda_ff <= {sda_ff[LAST-1:0], sda_i};
      scl_d  <= scl_ff[LAST];
      sda_d  <= sda_ff[LAST];
    end
  end

  assign scl_hi_o   = scl_ff[LAST];
  assign sda_hi_o   = sda_ff[LAST];
  assign scl_rise_o = scl_ff[LAST] & ~scl_d;
  assign scl_fall_o = ~scl_ff[LAST] & scl_d;
  assign start_o    = scl_ff[LAST] & scl_d & sda_d & ~sda_ff[LAST];
  assign stop_o     = scl_ff[LAST] & scl_d & ~sda_d & sda_ff[LAST];
endmodule

// File: rtl/i2cs_addr_ctr.sv
module i2cs_addr_ctr #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= q_o + 1'b1;
  end

  // R7
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i) |=> (q_o == ADDR_W'($past(q_o) + 1'b1)));
endmodule

// File: rtl/i2cs_byte_shift.sv
module i2cs_byte_shift
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              sin_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_val_i,
  output logic [BYTE_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {q_o[BYTE_W-2:0], sin_i};
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2cs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned CE_W        = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_ID      = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [CE_W-1:0]   chip_sel_i,
  input  logic              wr_busy_i,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [BYTE_W-1:0] mem_rd_data_i,
  output logic              mem_wr_en_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [BYTE_W-1:0] mem_wr_data_o
);
  localparam int unsigned AHI_W = ADDR_W - BYTE_W;
  localparam logic [3:0]  ACK_SLOT = 4'd8;
  localparam logic [3:0]  END_SLOT = 4'd9;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic scl_hi, sda_hi, scl_rise, scl_fall, ev_start, ev_stop;
  i2cs_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi_o(scl_hi), .sda_hi_o(sda_hi), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(ev_start), .stop_o(ev_stop));

  i2cs_state_e       st_q, st_d;
  logic [3:0]        bcnt_q, bcnt_d;
  logic              oe_q, oe_d, rw_q, rw_d, mack_q, mack_d;
  logic [AHI_W-1:0]  ahi_q, ahi_d;
  logic              wr_en_d;
  logic              sh_shift, sh_load, ctr_load, ctr_inc;
  logic [BYTE_W-1:0] sh_q;
  logic [ADDR_W-1:0] ctr_q;
  logic              dev_match;

  i2cs_byte_shift u_shift (
    .clk(clk), .rst_n(rst_core_n), .shift_i(sh_shift), .sin_i(sda_hi),
    .load_i(sh_load), .load_val_i(mem_rd_data_i), .q_o(sh_q));

  i2cs_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_core_n), .load_i(ctr_load),
    .load_val_i({ahi_q, sh_q}), .inc_i(ctr_inc), .q_o(ctr_q));

  assign dev_match = (sh_q[7:4] == DEV_ID) && (sh_q[3:1] == chip_sel_i) && !wr_busy_i;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    bcnt_d   = bcnt_q;
    oe_d     = oe_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    ahi_d    = ahi_q;
    wr_en_d  = 1'b0;
    sh_shift = 1'b0;
    sh_load  = 1'b0;
    ctr_load = 1'b0;
    ctr_inc  = 1'b0;
    if (ev_start) begin
      st_d   = ST_DEV;
      bcnt_d = '0;
      oe_d   = 1'b0;
    end else if (ev_stop) begin
      st_d   = ST_IDLE;
      bcnt_d = '0;
      oe_d   = 1'b0;
    end else if (st_q == ST_RDAT) begin
      if (scl_rise && bcnt_q < END_SLOT) begin
        bcnt_d = bcnt_q + 4'd1;
        if (bcnt_q == ACK_SLOT) mack_d = ~sda_hi;
      end
      if (scl_fall) begin
        if (bcnt_q != '0 && bcnt_q < ACK_SLOT) begin
          sh_shift = 1'b1;
          oe_d     = ~sh_q[6];
        end else if (bcnt_q == ACK_SLOT) begin
          oe_d    = 1'b0;
          ctr_inc = 1'b1;
        end else if (bcnt_q == END_SLOT) begin
          bcnt_d = '0;
          if (mack_q) begin
            sh_load = 1'b1;
            oe_d    = ~mem_rd_data_i[7];
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
    end else if (st_q != ST_IDLE) begin
      if (scl_rise && bcnt_q < END_SLOT) begin
        bcnt_d   = bcnt_q + 4'd1;
        sh_shift = (bcnt_q < ACK_SLOT);
      end
      if (scl_fall && bcnt_q == ACK_SLOT) begin
        oe_d = 1'b1;
        unique case (st_q)
          ST_DEV: begin
            oe_d = dev_match;
            rw_d = sh_q[0];
            if (!dev_match) st_d = ST_IDLE;
          end
          ST_AHI:  ahi_d = sh_q[AHI_W-1:0];
          ST_ALO:  ctr_load = 1'b1;
          ST_WDAT: begin
            wr_en_d = 1'b1;
            ctr_inc = 1'b1;
          end
          default: oe_d = 1'b0;
        endcase
      end else if (scl_fall && bcnt_q == END_SLOT) begin
        oe_d   = 1'b0;
        bcnt_d = '0;
        unique case (st_q)
          ST_DEV: begin
            if (rw_q) begin
              st_d    = ST_RDAT;
              sh_load = 1'b1;
              oe_d    = ~mem_rd_data_i[7];
            end else begin
              st_d = ST_AHI;
            end
          end
          ST_AHI:  st_d = ST_ALO;
          ST_ALO:  st_d = ST_WDAT;
          default: st_d = st_q;
        endcase
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q          <= ST_IDLE;
      bcnt_q        <= '0;
      oe_q          <= 1'b0;
      rw_q          <= 1'b0;
      mack_q        <= 1'b0;
      ahi_q         <= '0;
      mem_wr_en_o   <= 1'b0;
      mem_wr_addr_o <= '0;
      mem_wr_data_o <= '0;
    end else begin
      st_q        <= st_d;
      bcnt_q      <= bcnt_d;
      oe_q        <= oe_d;
      rw_q        <= rw_d;
      mack_q      <= mack_d;
      ahi_q       <= ahi_d;
      mem_wr_en_o <= wr_en_d;
      if (wr_en_d) begin
        mem_wr_addr_o <= ctr_q;
        mem_wr_data_o <= sh_q;
      end
    end
  end

  assign sda_oe_o      = oe_q;
  assign mem_rd_addr_o = ctr_q;

  // R9
  sda_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (scl_hi && $past(scl_hi)) |-> $stable(oe_q));

  // R2
  ack_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_DEV && $rose(oe_q)) |->
      ($past(sh_q[7:4]) == DEV_ID && $past(sh_q[3:1]) == $past(chip_sel_i)));

  // R3
  busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_DEV && $rose(oe_q)) |-> !$past(wr_busy_i));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_IDLE) |-> !oe_q);

  // R4
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_wr_en_o |=> !mem_wr_en_o);
endmodule

// File: tb/i2c_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb_top;
  localparam int H = 20;
  localparam logic [2:0] STRAP = 3'b101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        busy = 1'b0;
  logic        sda_oe;
  logic        sda_bus;
  logic [15:0] rd_addr, wr_addr;
  logic [7:0]  rd_data = 8'h00;
  logic [7:0]  wr_data;
  logic        wr_en;

  int total = 0;
  int bad = 0;
  bit quiet = 1'b0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  logic [7:0]  mem_m [int unsigned];
  logic [23:0] wq [$];

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_eeprom_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .chip_sel_i(STRAP), .wr_busy_i(busy), .mem_rd_addr_o(rd_addr),
    .mem_rd_data_i(rd_data), .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr),
    .mem_wr_data_o(wr_data));

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // RAM model with one cycle of read latency
  always @(posedge clk) begin
    rd_data <= exp_rd(rd_addr);
    if (wr_en) begin
      mem_m[int'(wr_addr)] = wr_data;
      wq.push_back({wr_addr, wr_data});
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      chk(!(quiet && sda_oe), "R2 slave quiet while master drives", int'(sda_oe), 0);
      chk(!(scl_m && prev_scl && sda_oe != prev_oe), "R9 drive stable in SCL high",
          int'(sda_oe), int'(prev_oe));
    end
    prev_scl = scl_m;
    prev_oe  = sda_oe;
  end

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hw(8); quiet = 1'b1; hw(H - 8);
      scl_m = 1'b1; hw(H); scl_m = 1'b0;
    end
    quiet = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H / 2);
    acked = (sda_bus == 1'b0);
    hw(H / 2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(H); scl_m = 1'b1; hw(H / 2); b[i] = sda_bus; hw(H / 2); scl_m = 1'b0;
    end
    sda_m = ~mack; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0;
  endtask

  task automatic exp_ack(input logic [7:0] b, input bit want, input string req);
    bit a;
    send_byte(b, a);
    chk(a == want, req, int'(a), int'(want));
  endtask

  task automatic exp_byte(input bit mack, input logic [7:0] want, input string req);
    logic [7:0] got;
    recv_byte(mack, got);
    chk(got == want, req, int'(got), int'(want));
  endtask

  task automatic exp_wr(input logic [15:0] a, input logic [7:0] d, input string req);
    logic [23:0] e;
    if (wq.size() == 0) begin
      chk(1'b0, req, 0, int'({a, d}));
    end else begin
      e = wq.pop_front();
      chk(e == {a, d}, req, int'(e), int'({a, d}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    hw(5); rst_n = 1'b1; hw(5);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 reset sda release", int'(sda_oe), 0);
    chk(wr_en == 1'b0, "R1 reset no write strobe", int'(wr_en), 0);
    mon_on = 1'b1;

    // R2 chip-enable mismatch, then following byte ignored
    i2c_start();
    exp_ack(8'hA8, 1'b0, "R2 strap mismatch nack");
    exp_ack(8'h12, 1'b0, "R2 ignored until Start");
    i2c_stop();
    i2c_start();
    exp_ack(8'hBA, 1'b0, "R2 identifier mismatch nack");
    i2c_stop();

    // R3 busy blocks select
    busy = 1'b1;
    i2c_start();
    exp_ack(8'hAA, 1'b0, "R3 busy select nack");
    i2c_stop();
    busy = 1'b0;

    // R4 write two bytes at 1234h
    i2c_start();
    exp_ack(8'hAA, 1'b1, "R4 write select ack");
    exp_ack(8'h12, 1'b1, "R4 high address ack");
    exp_ack(8'h34, 1'b1, "R4 low address ack");
    exp_ack(8'hAA, 1'b1, "R4 data ack");
    exp_ack(8'hBB, 1'b1, "R4 data ack");
    i2c_stop();
    exp_wr(16'h1234, 8'hAA, "R4 first strobe");
    exp_wr(16'h1235, 8'hBB, "R4 second strobe");

    // R5 current address read at 1236h, R8 NoAck then silence
    i2c_start();
    exp_ack(8'hAB, 1'b1, "R5 read select ack");
    exp_byte(1'b0, exp_rd(16'h1236), "R5 current address byte");
    exp_byte(1'b0, 8'hFF, "R8 silent after NoAck");
    i2c_stop();

    // R6 random read via dummy write, R7 sequential continuation
    i2c_start();
    exp_ack(8'hAA, 1'b1, "R6 dummy write select");
    exp_ack(8'h12, 1'b1, "R6 address high");
    exp_ack(8'h34, 1'b1, "R6 address low");
    i2c_start();
    exp_ack(8'hAB, 1'b1, "R6 read select after restart");
    exp_byte(1'b1, 8'hAA, "R6 random read byte");
    exp_byte(1'b0, 8'hBB, "R7 sequential next byte");
    i2c_stop();

    // R7 write across the top of the address space
    i2c_start();
    exp_ack(8'hAA, 1'b1, "R7 write select");
    exp_ack(8'hFF, 1'b1, "R7 address high");
    exp_ack(8'hFE, 1'b1, "R7 address low");
    exp_ack(8'h11, 1'b1, "R7 data");
    exp_ack(8'h22, 1'b1, "R7 data");
    exp_ack(8'h33, 1'b1, "R7 data");
    i2c_stop();
    exp_wr(16'hFFFE, 8'h11, "R7 strobe FFFE");
    exp_wr(16'hFFFF, 8'h22, "R7 strobe FFFF");
    exp_wr(16'h0000, 8'h33, "R7 strobe wraps to 0000");

    // R7 read across the wrap
    i2c_start();
    exp_ack(8'hAA, 1'b1, "R7 dummy write select");
    exp_ack(8'hFF, 1'b1, "R7 address high");
    exp_ack(8'hFF, 1'b1, "R7 address low");
    i2c_start();
    exp_ack(8'hAB, 1'b1, "R7 read select");
    exp_byte(1'b1, 8'h22, "R7 byte at FFFF");
    exp_byte(1'b0, 8'h33, "R7 read wraps to 0000");
    i2c_stop();

    // R10 restart after only the high address byte: counter stays 0001h
    i2c_start();
    exp_ack(8'hAA, 1'b1, "R10 write select");
    exp_ack(8'h40, 1'b1, "R10 high address only");
    i2c_start();
    exp_ack(8'hAB, 1'b1, "R10 select after restart");
    exp_byte(1'b0, exp_rd(16'h0001), "R10 counter not loaded");
    i2c_stop();

    // R10 restart inside the select byte
    i2c_start();
    send_bits(8'hA0, 4);
    i2c_start();
    exp_ack(8'hAB, 1'b1, "R10 select after mid-byte restart");
    exp_byte(1'b0, exp_rd(16'h0002), "R10 read after mid-byte restart");
    i2c_stop();

    hw(10);
    chk(wq.size() == 0, "R4 no spurious strobes", wq.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule